// File: doc/BRIEF.md
# Serial Flash Page-Write Engine

This block is the device side of a serial flash that accepts writes over an SPI mode 0 link. The host opens a frame by pulling chip select low, shifts in an opcode and then any address and data bytes, and closes the frame by raising chip select. A write-enable opcode arms a latch. A page-write opcode, valid only while that latch is armed, takes a 24-bit address and then a stream of data bytes. The bytes collect in a 256-byte staging buffer, and the write pointer wraps inside the addressed page. A status opcode streams back the busy flag and the latch state.

A page write is committed only if chip select rises exactly on a byte boundary after at least one data byte, the target page is not locked, and no earlier write is still running. When it is committed, a self-timed cycle copies every staged byte into the behavioural array, and the busy flag stays set until a parameterised cycle count has elapsed. The SPI pins are sampled by the system clock through synchronisers. A debug read port exposes the array so that a bench can inspect it directly.

Top module: `flash_page_writer`

## Requirements
- R1: After reset the busy flag (WIP) and the write-enable latch (WEL) are 0, a status read returns 0x00, and `spi_miso` is low. Every array byte powers up as 0xFF.
- R2: A frame holding only the byte 0x06 sets WEL. A frame with any bits after that byte leaves WEL unchanged. Opcode 0x05 returns the status byte MSB first, repeated for every following byte of the frame. Bit 1 of the status byte is WEL, bit 0 is WIP, and bits 7:2 are 0.
- R3: A page-write frame (opcode 0x0A) sent while WEL is 0 leaves the array unchanged.
- R4: The address is three bytes sent MSB first. Bits 23 down to MEM_AW are ignored, and the page is selected by address bits MEM_AW-1:8. The first data byte lands at page offset address[7:0], and each later byte lands at the next offset.
- R5: When the offset passes 255, the next byte lands at offset 0 of the same page.
- R6: When more than 256 data bytes are sent, each offset holds the last byte sent to it.
- R7: Offsets of the page that received no data byte keep their previous contents.
- R8: If chip select rises anywhere other than right after the eighth bit of a data byte (inside a byte, or before any data byte), nothing is written and WEL keeps its value.
- R9: An accepted frame sets WIP within 4 clocks of the chip-select rise. WIP stays set for max(WRITE_CYCLES, 256) clocks and then reads 0. WEL reads 0 from the start of that cycle.
- R10: A page write whose page has its `page_lock` bit set when the address completes is not executed, and WEL keeps its value.
- R11: A page write received while WIP is 1 is rejected, and the running cycle still commits exactly its own data. A write-enable frame is still accepted while WIP is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also samples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 (idle low) |
| spi_mosi | input | 1 | Serial data in, sampled on SCK rise |
| spi_miso | output | 1 | Serial data out, changes after SCK fall |
| page_lock | input | 2**(MEM_AW-8) | One write-protect bit per page |
| dbg_addr | input | MEM_AW | Debug read address into the array |
| dbg_data | output | 8 | Array byte at `dbg_addr`, combinational |

## Verification
Each SCK edge reaches the control logic about three system clocks after the pin toggles. The bench therefore holds every SCK level for six clocks and samples `spi_miso` just before it raises SCK, which is at least three clocks after the falling edge that shifted the bit out. WIP rises a few clocks after chip select goes high, so the status read that directly follows a write must see WIP set. The array is final only after the whole self-timed cycle, so array contents are compared only after a status poll returns WIP clear. The WIP release is also checked by reading status again once more than WRITE_CYCLES clocks have passed since the write frame closed.

// File: rtl/fpw_pkg.sv
// Package fpw_pkg
// Shared opcodes, page geometry and the command phase type for the page-write engine.
// Assumes byte-wide SPI transfers with the most significant bit first.
package fpw_pkg;
    localparam logic [7:0] OPC_ARM_WRITE  = 8'h06;
    localparam logic [7:0] OPC_GET_STATUS = 8'h05;
    localparam logic [7:0] OPC_PAGE_PROG  = 8'h0A;
    localparam int         PAGE_BYTES     = 256;
    localparam int         OFF_W          = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPCODE,
        PH_ADDR,
        PH_DATA,
        PH_STATUS,
        PH_DROP
    } phase_t;
endpackage

// File: rtl/fpw_link.sv
// Module fpw_link
// Brings the SPI pins into the system clock domain, finds SCK and chip-select
// edges, assembles received bytes and shifts the transmit byte out on MISO.
// Assumes SPI mode 0 and an SCK level held for at least SYNC_STAGES+1 clocks.
module fpw_link #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_pin,
    input  logic       sck_pin,
    input  logic       mosi_pin,
    input  logic [7:0] tx_byte,
    input  logic       tx_on,
    output logic       miso_pin,
    output logic       frame_open,
    output logic       frame_close,
    output logic       close_aligned,
    output logic       rx_stb,
    output logic [7:0] rx_byte
);
    localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [SW-1:0] cs_sy, sck_sy, mosi_sy;
    logic          cs_q, sck_q;
    logic          cs_lvl, sck_lvl, mosi_lvl;
    logic          sck_rise, sck_fall;
    logic [2:0]    bit_cnt;
    logic [6:0]    rx_sh;
    logic          any_byte;
    logic [6:0]    tx_sh;
    logic          miso_q;

    // Synchroniser chains for the three input pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sy   <= '1;
            sck_sy  <= '0;
            mosi_sy <= '0;
        end else begin
            cs_sy   <= {cs_sy[SW-2:0], cs_n_pin};
            sck_sy  <= {sck_sy[SW-2:0], sck_pin};
            mosi_sy <= {mosi_sy[SW-2:0], mosi_pin};
        end
    end

    assign cs_lvl   = cs_sy[SW-1];
    assign sck_lvl  = sck_sy[SW-1];
    assign mosi_lvl = mosi_sy[SW-1];

    // Previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_lvl;
            sck_q <= sck_lvl;
        end
    end

    assign sck_rise      = sck_lvl & ~sck_q & ~cs_lvl;
    assign sck_fall      = ~sck_lvl & sck_q & ~cs_lvl;
    assign frame_open    = ~cs_lvl & cs_q;
    assign frame_close   = cs_lvl & ~cs_q;
    assign close_aligned = (bit_cnt == 3'd0) && any_byte;

    // Receive shift register and bit position within the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= 3'd0;
            rx_sh    <= '0;
            any_byte <= 1'b0;
            rx_stb   <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_stb <= 1'b0;
            if (frame_open) begin
                bit_cnt  <= 3'd0;
                any_byte <= 1'b0;
            end else if (sck_rise) begin
                rx_sh   <= {rx_sh[5:0], mosi_lvl};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    any_byte <= 1'b1;
                    rx_stb   <= 1'b1;
                    rx_byte  <= {rx_sh, mosi_lvl};
                end
            end
        end
    end

    // Transmit shifter: a new byte is loaded on the first falling edge of each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            miso_q <= 1'b0;
        end else if (frame_open) begin
            miso_q <= 1'b0;
        end else if (sck_fall) begin
            if (bit_cnt == 3'd0) begin
                miso_q <= tx_byte[7];
                tx_sh  <= tx_byte[6:0];
            end else begin
                miso_q <= tx_sh[6];
                tx_sh  <= {tx_sh[5:0], 1'b0};
            end
        end
    end

    assign miso_pin = tx_on & miso_q;
endmodule

// File: rtl/fpw_ctrl.sv
// Module fpw_ctrl
// Decodes the opcode, collects the address, stages data bytes in a page buffer
// with per-offset valid flags and decides at chip-select rise whether to commit.
// Assumes busy cannot start while a frame is open (only this block starts it).
module fpw_ctrl
    import fpw_pkg::*;
#(
    parameter int MEM_AW = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_open,
    input  logic                     frame_close,
    input  logic                     close_aligned,
    input  logic                     rx_stb,
    input  logic [7:0]               rx_byte,
    input  logic                     busy,
    input  logic [(1<<(MEM_AW-8))-1:0] page_lock,
    input  logic [OFF_W-1:0]         rd_idx,
    output logic [7:0]               rd_byte,
    output logic                     rd_valid,
    output logic                     commit_go,
    output logic [MEM_AW-9:0]        commit_page,
    output logic                     wel,
    output logic                     tx_on
);
    localparam int PAGE_W = MEM_AW - 8;

    phase_t                phase;
    logic [1:0]            addr_n;
    logic [PAGE_W-1:0]     page_acc;
    logic [PAGE_W-1:0]     page_q;
    logic [OFF_W-1:0]      ptr;
    logic                  got_data;
    logic                  arm_seen;
    logic                  take_data;
    logic                  addr_last;
    logic                  wel_set;
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;

    assign take_data = rx_stb && (phase == PH_DATA);
    assign addr_last = rx_stb && (phase == PH_ADDR) && (addr_n == 2'd2);
    assign commit_go = frame_close && (phase == PH_DATA) && got_data && close_aligned;
    assign wel_set   = frame_close && arm_seen && close_aligned;

    // Command phase sequencing, address capture and data pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            addr_n   <= 2'd0;
            page_acc <= '0;
            page_q   <= '0;
            ptr      <= '0;
            got_data <= 1'b0;
            arm_seen <= 1'b0;
        end else if (frame_open) begin
            phase    <= PH_OPCODE;
            addr_n   <= 2'd0;
            got_data <= 1'b0;
            arm_seen <= 1'b0;
        end else if (frame_close) begin
            phase    <= PH_IDLE;
            arm_seen <= 1'b0;
        end else if (rx_stb) begin
            unique case (phase)
                PH_OPCODE: begin
                    if (rx_byte == OPC_ARM_WRITE) begin
                        arm_seen <= 1'b1;
                        phase    <= PH_DROP;
                    end else if (rx_byte == OPC_GET_STATUS) begin
                        phase <= PH_STATUS;
                    end else if (rx_byte == OPC_PAGE_PROG && wel && !busy) begin
                        phase <= PH_ADDR;
                    end else begin
                        phase <= PH_DROP;
                    end
                end
                PH_ADDR: begin
                    addr_n <= addr_n + 2'd1;
                    if (addr_n == 2'd2) begin
                        page_q <= page_acc;
                        ptr    <= rx_byte;
                        phase  <= page_lock[page_acc] ? PH_DROP : PH_DATA;
                    end else begin
                        page_acc <= PAGE_W'({page_acc, rx_byte});
                    end
                end
                PH_DATA: begin
                    ptr      <= ptr + 8'd1;
                    got_data <= 1'b1;
                end
                PH_DROP: begin
                    arm_seen <= 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    // Page buffer storage; offsets wrap because the pointer is eight bits.
    always_ff @(posedge clk) begin
        if (take_data) begin
            pbuf[ptr] <= rx_byte;
        end
    end

    // Per-offset flags marking which buffer bytes belong to the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pvalid <= '0;
        end else if (addr_last) begin
            pvalid <= '0;
        end else if (take_data) begin
            pvalid[ptr] <= 1'b1;
        end
    end

    // Write-enable latch: armed by a clean enable frame, dropped when a write starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (commit_go) begin
            wel <= 1'b0;
        end else if (wel_set) begin
            wel <= 1'b1;
        end
    end

    assign rd_byte     = pbuf[rd_idx];
    assign rd_valid    = pvalid[rd_idx];
    assign commit_page = page_q;
    assign tx_on       = (phase == PH_STATUS);
endmodule

// File: rtl/fpw_store.sv
// Module fpw_store
// Behavioural byte array plus the self-timed write cycle: walks the 256 offsets,
// copies flagged buffer bytes into the selected page, then holds busy to the end.
// Assumes the staging buffer stays unchanged while busy is set.
module fpw_store
    import fpw_pkg::*;
#(
    parameter int MEM_AW       = 11,
    parameter int WRITE_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_go,
    input  logic [MEM_AW-9:0] commit_page,
    output logic [OFF_W-1:0]  rd_idx,
    input  logic [7:0]        rd_byte,
    input  logic              rd_valid,
    output logic              busy,
    output logic              mem_we,
    output logic [MEM_AW-9:0] wr_page,
    input  logic [MEM_AW-1:0] dbg_addr,
    output logic [7:0]        dbg_data
);
    localparam int MEM_BYTES = 1 << MEM_AW;
    localparam int TIMER_END = (WRITE_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WRITE_CYCLES;
    localparam int CNT_W     = $clog2(TIMER_END + 1);

    logic [CNT_W-1:0] cnt;
    logic             active;
    logic [7:0]       cells [MEM_BYTES];

    // Array powers up erased.
    initial begin
        for (int i = 0; i < MEM_BYTES; i++) begin
            cells[i] = 8'hFF;
        end
    end

    // Cycle timer: runs for TIMER_END clocks once a commit is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt     <= '0;
            wr_page <= '0;
        end else if (!active) begin
            if (commit_go) begin
                active  <= 1'b1;
                cnt     <= '0;
                wr_page <= commit_page;
            end
        end else begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(TIMER_END - 1)) begin
                active <= 1'b0;
            end
        end
    end

    assign rd_idx = cnt[OFF_W-1:0];
    assign mem_we = active && (cnt < CNT_W'(PAGE_BYTES)) && rd_valid;
    assign busy   = active;

    // Array write port, one staged byte per clock during the copy phase.
    always_ff @(posedge clk) begin
        if (mem_we) begin
            cells[{wr_page, rd_idx}] <= rd_byte;
        end
    end

    assign dbg_data = cells[dbg_addr];
endmodule

// File: rtl/flash_page_writer.sv
// Module flash_page_writer
// Top of the serial flash page-write engine: SPI link, command control with
// staging buffer, and the array with its self-timed write cycle.
// Assumes the SPI pins are asynchronous to clk and SCK is slower than clk/6.
module flash_page_writer #(
    parameter int MEM_AW       = 11,
    parameter int WRITE_CYCLES = 1000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_cs_n,
    input  logic                       spi_sck,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    input  logic [(1<<(MEM_AW-8))-1:0] page_lock,
    input  logic [MEM_AW-1:0]          dbg_addr,
    output logic [7:0]                 dbg_data
);
    localparam int PAGE_W = MEM_AW - 8;

    logic              frame_open_w, frame_close_w, close_aligned_w;
    logic              rx_stb_w;
    logic [7:0]        rx_byte_w;
    logic              busy_w, wel_w, tx_on_w;
    logic              commit_go_w;
    logic [PAGE_W-1:0] commit_page_w;
    logic [PAGE_W-1:0] wr_page_w;
    logic              mem_we_w;
    logic [7:0]        rd_idx_w;
    logic [7:0]        rd_byte_w;
    logic              rd_valid_w;
    logic [7:0]        status_w;

    assign status_w = {6'b0, wel_w, busy_w};

    fpw_link #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_link (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_pin     (spi_cs_n),
        .sck_pin      (spi_sck),
        .mosi_pin     (spi_mosi),
        .tx_byte      (status_w),
        .tx_on        (tx_on_w),
        .miso_pin     (spi_miso),
        .frame_open   (frame_open_w),
        .frame_close  (frame_close_w),
        .close_aligned(close_aligned_w),
        .rx_stb       (rx_stb_w),
        .rx_byte      (rx_byte_w)
    );

    fpw_ctrl #(
        .MEM_AW(MEM_AW)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_open   (frame_open_w),
        .frame_close  (frame_close_w),
        .close_aligned(close_aligned_w),
        .rx_stb       (rx_stb_w),
        .rx_byte      (rx_byte_w),
        .busy         (busy_w),
        .page_lock    (page_lock),
        .rd_idx       (rd_idx_w),
        .rd_byte      (rd_byte_w),
        .rd_valid     (rd_valid_w),
        .commit_go    (commit_go_w),
        .commit_page  (commit_page_w),
        .wel          (wel_w),
        .tx_on        (tx_on_w)
    );

    fpw_store #(
        .MEM_AW      (MEM_AW),
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_go  (commit_go_w),
        .commit_page(commit_page_w),
        .rd_idx     (rd_idx_w),
        .rd_byte    (rd_byte_w),
        .rd_valid   (rd_valid_w),
        .busy       (busy_w),
        .mem_we     (mem_we_w),
        .wr_page    (wr_page_w),
        .dbg_addr   (dbg_addr),
        .dbg_data   (dbg_data)
    );
endmodule

// File: rtl/fpw_checker.sv
// Module fpw_checker
// Temporal checks on the page-write engine, bound into flash_page_writer.
// Assumes page_lock is held steady while a write cycle runs.
module fpw_checker #(
    parameter int MEM_AW       = 11,
    parameter int WRITE_CYCLES = 1000
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       busy,
    input logic                       wel,
    input logic                       commit_go,
    input logic                       mem_we,
    input logic [MEM_AW-9:0]          wr_page,
    input logic [(1<<(MEM_AW-8))-1:0] page_lock,
    input logic                       spi_miso
);
    localparam int TIMER_END = (WRITE_CYCLES < 256) ? 256 : WRITE_CYCLES;
    localparam int RUN_W     = $clog2(TIMER_END + 2);

    logic [RUN_W-1:0] run_len;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !wel && !spi_miso));

    a_r3_commit_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |-> wel);

    a_r9_start_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |=> (busy && !wel));

    a_r9_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == RUN_W'(TIMER_END)));

    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !commit_go);

    a_r10_locked_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !page_lock[wr_page]);
endmodule

bind flash_page_writer fpw_checker #(
    .MEM_AW      (MEM_AW),
    .WRITE_CYCLES(WRITE_CYCLES)
) u_fpw_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_w),
    .wel      (wel_w),
    .commit_go(commit_go_w),
    .mem_we   (mem_we_w),
    .wr_page  (wr_page_w),
    .page_lock(page_lock),
    .spi_miso (spi_miso)
);

// File: tb/flash_page_writer_bench.sv
`timescale 1ns/1ps
module flash_page_writer_bench;
    localparam int MEM_AW = 11;
    localparam int WCYC   = 1000;
    localparam int NBYTES = 1 << MEM_AW;
    localparam int HALF   = 6;
    localparam logic [7:0] LOCKS = 8'b0010_0000;

    typedef struct packed {
        logic        wren;
        logic [23:0] addr;
        logic [9:0]  nbytes;
        logic [2:0]  tail;
        logic [7:0]  seed;
        logic [3:0]  req;
    } vec_t;

    // Scenario table: optional enable frame, address, data count, trailing bits, pattern seed, requirement.
    localparam vec_t VECS [9] = '{
        '{1'b1, 24'h000100, 10'd16,  3'd0, 8'h11, 4'd7},  // R7 R4 short write
        '{1'b1, 24'hFC02F0, 10'd32,  3'd0, 8'h22, 4'd5},  // R5 wrap, R4 high bits ignored
        '{1'b1, 24'h000310, 10'd300, 3'd0, 8'h40, 4'd6},  // R6 overrun keeps last 256
        '{1'b0, 24'h000400, 10'd8,   3'd0, 8'h55, 4'd3},  // R3 no enable
        '{1'b1, 24'h000500, 10'd4,   3'd0, 8'h66, 4'd10}, // R10 locked page
        '{1'b0, 24'h000600, 10'd5,   3'd3, 8'h77, 4'd8},  // R8 mid-byte rise
        '{1'b0, 24'h000680, 10'd0,   3'd0, 8'h88, 4'd8},  // R8 no data byte
        '{1'b0, 24'h000640, 10'd10,  3'd0, 8'h99, 4'd2},  // R2 latch survived rejects
        '{1'b1, 24'h0007FF, 10'd2,   3'd0, 8'hA0, 4'd5}   // R5 wrap at last offset
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cs_n = 1'b1;
    logic                sck = 1'b0;
    logic                mosi = 1'b0;
    logic                miso;
    logic [MEM_AW-1:0]   dbg_addr = '0;
    logic [7:0]          dbg_data;
    logic [7:0]          exp_mem [NBYTES];
    logic                wel_m = 1'b0;
    int                  checks = 0;
    int                  fails = 0;
    bit                  done = 1'b0;

    always #2.5 clk = ~clk;

    flash_page_writer #(
        .MEM_AW(MEM_AW),
        .WRITE_CYCLES(WCYC)
    ) u_flash_page_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs_n (cs_n),
        .spi_sck  (sck),
        .spi_mosi (mosi),
        .spi_miso (miso),
        .page_lock(LOCKS),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b, output logic r);
        @(negedge clk);
        mosi = b;
        wait_clk(HALF);
        r = miso;
        sck = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            logic r;
            spi_bit(tx[b], r);
            rx[b] = r;
        end
    endtask

    task automatic cs_low();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_high();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic arm_frame(input int extra_bits);
        logic [7:0] rx;
        logic r;
        cs_low();
        spi_byte(8'h06, rx);
        for (int i = 0; i < extra_bits; i++) spi_bit(1'b1, r);
        cs_high();
    endtask

    task automatic read_status(input int nread, output logic [7:0] s0, output logic [7:0] s1);
        logic [7:0] rx;
        cs_low();
        spi_byte(8'h05, rx);
        spi_byte(8'h00, s0);
        s1 = s0;
        if (nread > 1) spi_byte(8'h00, s1);
        cs_high();
    endtask

    task automatic send_pw(input logic [23:0] addr, input int n, input int tail, input logic [7:0] seed);
        logic [7:0] rx;
        logic r;
        cs_low();
        spi_byte(8'h0A, rx);
        spi_byte(addr[23:16], rx);
        spi_byte(addr[15:8], rx);
        spi_byte(addr[7:0], rx);
        for (int i = 0; i < n; i++) spi_byte(8'(seed + 8'(i * 3)), rx);
        for (int i = 0; i < tail; i++) spi_bit(1'b0, r);
        cs_high();
    endtask

    // Updates the bench model for a page-write frame sent while the model is idle.
    task automatic model_pw(input logic [23:0] addr, input int n, input int tail, input logic [7:0] seed, input logic idle);
        logic [2:0] pg;
        pg = addr[MEM_AW-1:8];
        if (wel_m && idle && !LOCKS[pg] && tail == 0 && n > 0) begin
            for (int i = 0; i < n; i++)
                exp_mem[{pg, 8'(addr[7:0] + 8'(i))}] = 8'(seed + 8'(i * 3));
            wel_m = 1'b0;
        end
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] s0, s1;
        bit idle;
        idle = 1'b0;
        for (int k = 0; k < 40 && !idle; k++) begin
            read_status(1, s0, s1);
            idle = !s0[0];
        end
        check({req, " WIP clears"}, {31'd0, idle}, 32'd1);
    endtask

    task automatic check_array(input string req);
        int mism;
        int first;
        mism = 0;
        first = -1;
        for (int a = 0; a < NBYTES; a++) begin
            dbg_addr = a[MEM_AW-1:0];
            #0.1;
            if (dbg_data !== exp_mem[a]) begin
                mism++;
                if (first < 0) first = a;
            end
        end
        check($sformatf("%s array mismatches (first at %0d)", req, first), mism, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] s0, s1;
        for (int a = 0; a < NBYTES; a++) exp_mem[a] = 8'hFF;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);

        // R1 reset state
        check("R1 miso low after reset", {31'd0, miso}, 32'd0);
        read_status(1, s0, s1);
        check("R1 status after reset", s0, 8'h00);
        check_array("R1 erased array");

        // Table walk
        for (int v = 0; v < 9; v++) begin
            if (VECS[v].wren) begin
                arm_frame(0);
                wel_m = 1'b1;
            end
            model_pw(VECS[v].addr, int'(VECS[v].nbytes), int'(VECS[v].tail), VECS[v].seed, 1'b1);
            send_pw(VECS[v].addr, int'(VECS[v].nbytes), int'(VECS[v].tail), VECS[v].seed);
            wait_idle($sformatf("R%0d vector %0d", VECS[v].req, v));
            check_array($sformatf("R%0d vector %0d", VECS[v].req, v));
            read_status(1, s0, s1);
            check($sformatf("R%0d vector %0d WEL", VECS[v].req, v), s0, {6'd0, wel_m, 1'b0});
        end

        // R9 busy window and WEL clear
        arm_frame(0);
        wel_m = 1'b1;
        model_pw(24'h000020, 1, 0, 8'h5A, 1'b1);
        send_pw(24'h000020, 1, 0, 8'h5A);
        read_status(1, s0, s1);
        check("R9 WIP set, WEL clear during cycle", s0, 8'h01);
        wait_clk(WCYC);
        read_status(1, s0, s1);
        check("R9 WIP clear after cycle", s0, 8'h00);
        check_array("R9 single byte committed");

        // R11 write during busy is rejected, enable still accepted
        arm_frame(0);
        wel_m = 1'b1;
        model_pw(24'h000180, 4, 0, 8'hC0, 1'b1);
        send_pw(24'h000180, 4, 0, 8'hC0);
        arm_frame(0);
        wel_m = 1'b1;
        read_status(1, s0, s1);
        check("R11 enable accepted while busy", s0, 8'h03);
        model_pw(24'h000000, 8, 0, 8'hE0, 1'b0);
        send_pw(24'h000000, 8, 0, 8'hE0);
        wait_idle("R11");
        check_array("R11 busy reject, running cycle intact");
        read_status(2, s0, s1);
        check("R11 WEL kept after rejected write", s0, 8'h02);
        check("R2 status repeats on next byte", s1, 8'h02);

        // R1 mid-run reset, then R2 enable framing
        @(negedge clk);
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wel_m = 1'b0;
        wait_clk(3);
        read_status(1, s0, s1);
        check("R1 status after second reset", s0, 8'h00);
        arm_frame(3);
        read_status(1, s0, s1);
        check("R2 enable with trailing bits ignored", s0, 8'h00);
        arm_frame(0);
        read_status(1, s0, s1);
        check("R2 clean enable frame sets WEL", s0, 8'h02);
        check_array("R1 array kept across reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule